// File: doc/BRIEF.md
# Extended-Precision Floating-Point Compare and Classify Unit

This unit takes two 80-bit extended-precision operands, each a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. It either orders them, orders operand A against +0.0, or classifies operand A on its own. A compare always yields exactly one of four relations: greater, less, equal or unordered. The relation is written to one of two three-bit result groups. The condition-code group `cc` holds {C3,C2,C0}. The flag group `flg` holds {ZF,PF,CF}. The opcode picks which group carries the result. Depending on the compare mode, the unit also raises an invalid-operation indication. Trapping, stack handling and integer conversion are left to the surrounding pipeline.

An operation is launched by holding `in_valid` high for one clock with `op`, `opa`, `opb` and `a_empty` stable. Every strobe is accepted, because the unit computes in one cycle and can never stall. There is no ready signal and no back-pressure. Strobes may arrive back to back, one per clock. The results are registered. `done` pulses in the cycle after each strobe, and the result pins hold their values until the next strobe.

Opcode encoding (`op`):
- 000: signalling compare into `cc`
- 001: quiet compare into `cc`
- 010: signalling compare into `flg`
- 011: quiet compare into `flg`
- 100: test A against zero into `cc`
- 101: classify A
- 110 and 111: reserved

Top module: `fpcmp_unit`

## Requirements
- R1: For compare opcodes 000, 001 and 100, `cc` = 000 when A>B, 001 when A<B, 100 when A=B and 111 when unordered. In all these cases `flg` = 000 and `c1` = 0.
- R2: For opcodes 010 and 011, `flg` carries the relation with the same four codes (000 greater, 001 less, 100 equal, 111 unordered), while `cc` = 000 and `c1` = 0.
- R3: The relation is unordered when either operand is a NaN or an unsupported encoding. The encodings are:
  - NaN: exponent 7FFF, integer bit (bit 63) set, fraction bits [62:0] nonzero.
  - Unsupported: integer bit clear with a nonzero exponent, including exponent 7FFF.
- R4: Signalling compares (opcodes 000, 010 and 100) assert `invalid` for every unordered result.
- R5: Quiet compares (opcodes 001 and 011) assert `invalid` only when an operand is a signalling NaN or unsupported. A signalling NaN is a NaN with bit 62 clear. Quiet NaNs, which have bit 62 set, give 111 with `invalid` = 0.
- R6: Opcode 100 compares A with +0.0 as a signalling compare, and the value on `opb` has no effect.
- R7: +0.0 and -0.0 compare equal. Other ordered values are ranked first by sign (positive above negative), then by biased exponent, then by the 64-bit significand. The magnitude order is reversed when both operands are negative.
- R8: Classify (opcode 101) puts a class code on `cc`:
  - 000 unsupported
  - 001 NaN
  - 010 normal
  - 011 infinity
  - 100 zero (exponent 0, significand 0)
  - 101 empty, whenever `a_empty` = 1, whatever A holds
  - 110 denormal (exponent 0, significand nonzero)
  
  `a_empty` is used by classify only.
- R9: Classify drives `c1` with A's sign bit (bit 79) and gives `flg` = 000 and `invalid` = 0.
- R10: `done` is high exactly in the cycle after `in_valid` was high. The result pins change only in the cycle after a strobe.
- R11: Reserved opcodes 110 and 111 return `cc`, `flg`, `c1` and `invalid` all zero, still with a `done` pulse.
- R12: While reset is held, `done`, `cc`, `c1`, `flg` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Launch strobe, one operation per high cycle |
| op | input | 3 | Operation select (see encoding above) |
| opa | input | 80 | Operand A |
| opb | input | 80 | Operand B, ignored for test-zero and classify |
| a_empty | input | 1 | Marks operand A's register as empty (classify only) |
| done | output | 1 | Result strobe, one cycle after `in_valid` |
| cc | output | 3 | {C3,C2,C0}: relation or class code |
| c1 | output | 1 | Sign of A on classify, else 0 |
| flg | output | 3 | {ZF,PF,CF}: relation for the flag-group opcodes |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The assertions check the following on every cycle:
- The one-cycle `done` timing, and that results hold between strobes.
- That compare codes stay within the four legal relation patterns and only one group is ever nonzero.
- That `invalid` never appears without an unordered code, and always appears with one under signalling mode.
- That `c1` follows A's sign on classify.

Only the bench's scenarios can show whether a given pair of values lands on the right relation. This covers signed zeros, negative magnitude inversion, denormals against infinities, and quiet against signalling NaNs in quiet mode. The same applies to `opb` having no effect on test-zero, and to `a_empty` overriding the class code.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    OP_SIG_CC   = 3'b000,
    OP_QUIET_CC = 3'b001,
    OP_SIG_FL   = 3'b010,
    OP_QUIET_FL = 3'b011,
    OP_TSTZ     = 3'b100,
    OP_CLASS    = 3'b101
  } fpcmp_op_e;

  typedef enum logic [2:0] {
    CL_UNSUP  = 3'b000,
    CL_NAN    = 3'b001,
    CL_NORM   = 3'b010,
    CL_INF    = 3'b011,
    CL_ZERO   = 3'b100,
    CL_EMPTY  = 3'b101,
    CL_DENORM = 3'b110
  } fp_class_e;

  typedef struct packed {
    logic      is_nan;
    logic      is_snan;
    logic      is_unsup;
    logic      is_zero;
    fp_class_e cls;
  } fp_info_t;

  localparam logic [2:0] REL_GT    = 3'b000;
  localparam logic [2:0] REL_LT    = 3'b001;
  localparam logic [2:0] REL_EQ    = 3'b100;
  localparam logic [2:0] REL_UNORD = 3'b111;

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] val,
  output fp_info_t             info
);
  localparam int W = 1 + EXP_W + SIG_W;

  logic [EXP_W-1:0] expo;
  logic [SIG_W-1:0] sig;
  logic             jbit;
  logic             qbit;
  logic             frac_nz;

  assign expo    = val[W-2:SIG_W];
  assign sig     = val[SIG_W-1:0];
  assign jbit    = sig[SIG_W-1];
  assign qbit    = sig[SIG_W-2];
  assign frac_nz = |sig[SIG_W-2:0];

  always_comb begin
    info = '{is_nan: 1'b0, is_snan: 1'b0, is_unsup: 1'b0, is_zero: 1'b0, cls: CL_NORM};
    if (expo == '0) begin
      if (sig == '0) begin
        info.is_zero = 1'b1;
        info.cls     = CL_ZERO;
      end else begin
        info.cls = CL_DENORM;
      end
    end else if (&expo) begin
      if (!jbit) begin
        info.is_unsup = 1'b1;
        info.cls      = CL_UNSUP;
      end else if (!frac_nz) begin
        info.cls = CL_INF;
      end else begin
        info.is_nan  = 1'b1;
        info.is_snan = ~qbit;
        info.cls     = CL_NAN;
      end
    end else if (!jbit) begin
      info.is_unsup = 1'b1;
      info.cls      = CL_UNSUP;
    end
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] a,
  input  logic [EXP_W+SIG_W:0] b,
  input  logic                 a_zero,
  input  logic                 b_zero,
  output logic                 gt,
  output logic                 lt,
  output logic                 eq
);
  localparam int W = 1 + EXP_W + SIG_W;

  logic [W-2:0] mag_a, mag_b;
  logic         mag_gt, mag_eq;

  assign mag_a  = a[W-2:0];
  assign mag_b  = b[W-2:0];
  assign mag_gt = mag_a > mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    gt = 1'b0;
    lt = 1'b0;
    eq = 1'b0;
    if (a_zero && b_zero) begin
      eq = 1'b1;
    end else if (a[W-1] != b[W-1]) begin
      gt = ~a[W-1];
      lt = a[W-1];
    end else if (mag_eq) begin
      eq = 1'b1;
    end else if (a[W-1]) begin
      gt = ~mag_gt;
      lt = mag_gt;
    end else begin
      gt = mag_gt;
      lt = ~mag_gt;
    end
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [EXP_W+SIG_W:0] opa,
  input  logic [EXP_W+SIG_W:0] opb,
  input  logic                 a_empty,
  output logic                 done,
  output logic [2:0]           cc,
  output logic                 c1,
  output logic [2:0]           flg,
  output logic                 invalid
);
  localparam int W = 1 + EXP_W + SIG_W;
  localparam int N_OPND = 2;

  logic [W-1:0] opnd [N_OPND];
  fp_info_t     info [N_OPND];
  logic         rel_gt, rel_lt, rel_eq;
  logic         unord, any_signal, any_unsup;
  logic [2:0]   rel;
  logic [2:0]   cc_d, flg_d;
  logic         c1_d, inv_d;
  logic [2:0]   op_q;

  assign opnd[0] = opa;
  assign opnd[1] = (op == OP_TSTZ) ? '0 : opb;

  for (genvar i = 0; i < N_OPND; i++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .val  (opnd[i]),
      .info (info[i])
    );
  end

  fpcmp_order #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_ord (
    .a      (opnd[0]),
    .b      (opnd[1]),
    .a_zero (info[0].is_zero),
    .b_zero (info[1].is_zero),
    .gt     (rel_gt),
    .lt     (rel_lt),
    .eq     (rel_eq)
  );

  assign unord      = info[0].is_nan | info[0].is_unsup | info[1].is_nan | info[1].is_unsup;
  assign any_signal = info[0].is_snan | info[1].is_snan;
  assign any_unsup  = info[0].is_unsup | info[1].is_unsup;

  always_comb begin
    if (unord)       rel = REL_UNORD;
    else if (rel_eq) rel = REL_EQ;
    else if (rel_lt) rel = REL_LT;
    else if (rel_gt) rel = REL_GT;
    else             rel = REL_GT;
  end

  always_comb begin
    cc_d  = 3'b000;
    flg_d = 3'b000;
    c1_d  = 1'b0;
    inv_d = 1'b0;
    case (op)
      OP_SIG_CC, OP_TSTZ: begin
        cc_d  = rel;
        inv_d = unord;
      end
      OP_QUIET_CC: begin
        cc_d  = rel;
        inv_d = unord & (any_signal | any_unsup);
      end
      OP_SIG_FL: begin
        flg_d = rel;
        inv_d = unord;
      end
      OP_QUIET_FL: begin
        flg_d = rel;
        inv_d = unord & (any_signal | any_unsup);
      end
      OP_CLASS: begin
        cc_d = a_empty ? CL_EMPTY : info[0].cls;
        c1_d = opa[W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      cc      <= 3'b000;
      flg     <= 3'b000;
      c1      <= 1'b0;
      invalid <= 1'b0;
      op_q    <= 3'b111;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        cc      <= cc_d;
        flg     <= flg_d;
        c1      <= c1_d;
        invalid <= inv_d;
        op_q    <= op;
      end
    end
  end

  logic cmp_q, sig_q;
  assign cmp_q = op_q inside {OP_SIG_CC, OP_QUIET_CC, OP_SIG_FL, OP_QUIET_FL, OP_TSTZ};
  assign sig_q = op_q inside {OP_SIG_CC, OP_SIG_FL, OP_TSTZ};

  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);
  assert_done_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cc) && $stable(flg) && $stable(c1) && $stable(invalid)));
  assert_code_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmp_q) |-> (cc inside {3'b000, 3'b001, 3'b100, 3'b111}));
  assert_group_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmp_q) |-> (cc == 3'b000 || flg == 3'b000));
  assert_inv_unord_R3: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (cc == 3'b111 || flg == 3'b111));
  assert_sig_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sig_q && (cc == 3'b111 || flg == 3'b111)) |-> invalid);
  assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_CLASS) |=> (c1 == $past(opa[W-1]) && !invalid && flg == 3'b000));

endmodule

// File: tb/sim_fpcmp_unit.sv
`timescale 1ns/1ps
module sim_fpcmp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'b000;
  logic [79:0] opa = '0;
  logic [79:0] opb = '0;
  logic        a_empty = 1'b0;
  logic        done, c1, invalid;
  logic [2:0]  cc, flg;

  int total = 0;
  int bad = 0;
  bit fin = 0;
  string cur_tag = "R12";

  always #2.5 clk = ~clk;

  fpcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .a_empty(a_empty), .done(done), .cc(cc), .c1(c1), .flg(flg), .invalid(invalid)
  );

  localparam logic [79:0] P_ZERO = 80'h0000_0000000000000000;
  localparam logic [79:0] N_ZERO = 80'h8000_0000000000000000;
  localparam logic [79:0] P_ONE  = 80'h3FFF_8000000000000000;
  localparam logic [79:0] N_ONE  = 80'hBFFF_8000000000000000;
  localparam logic [79:0] P_TWO  = 80'h4000_8000000000000000;
  localparam logic [79:0] N_TWO  = 80'hC000_8000000000000000;
  localparam logic [79:0] P_1P5  = 80'h3FFF_C000000000000000;
  localparam logic [79:0] P_INF  = 80'h7FFF_8000000000000000;
  localparam logic [79:0] N_INF  = 80'hFFFF_8000000000000000;
  localparam logic [79:0] QNAN   = 80'h7FFF_C000000000000000;
  localparam logic [79:0] SNAN   = 80'h7FFF_A000000000000000;
  localparam logic [79:0] DENORM = 80'h0000_0000000000000001;
  localparam logic [79:0] UNNORM = 80'h3FFF_4000000000000000;
  localparam logic [79:0] PSINF  = 80'h7FFF_0000000000000000;

  function automatic int ref_class(logic [79:0] v);
    if (v[78:64] == 15'd0) return (v[63:0] == 64'd0) ? 4 : 6;
    if (v[78:64] == 15'h7FFF) begin
      if (v[63] == 1'b0) return 0;
      return (v[62:0] == 63'd0) ? 3 : 1;
    end
    return v[63] ? 2 : 0;
  endfunction

  function automatic logic [79:0] ref_key(logic [79:0] v);
    logic [79:0] m;
    m = {1'b0, v[78:0]};
    if (m == 80'd0) return 80'h8000_0000000000000000;
    if (v[79]) return 80'h7FFF_FFFFFFFFFFFFFFFF - m;
    return 80'h8000_0000000000000000 + m;
  endfunction

  logic       m_done = 0, m_c1 = 0, m_inv = 0;
  logic [2:0] m_cc = 0, m_flg = 0;
  string      m_tag = "R12";

  always @(posedge clk) begin
    logic [79:0] bb;
    int ca, cb;
    bit un, sn;
    logic [2:0] rel;
    if (!rst_n) begin
      m_done <= 0; m_cc <= 0; m_flg <= 0; m_c1 <= 0; m_inv <= 0;
    end else if (in_valid) begin
      m_done <= 1;
      m_tag  <= cur_tag;
      m_cc <= 0; m_flg <= 0; m_c1 <= 0; m_inv <= 0;
      if (op <= 3'd4) begin
        bb = (op == 3'd4) ? 80'd0 : opb;
        ca = ref_class(opa);
        cb = ref_class(bb);
        un = (ca <= 1) || (cb <= 1);
        sn = (ca == 1 && !opa[62]) || (cb == 1 && !bb[62]);
        if (un) rel = 3'b111;
        else if (ref_key(opa) == ref_key(bb)) rel = 3'b100;
        else if (ref_key(opa) < ref_key(bb)) rel = 3'b001;
        else rel = 3'b000;
        if (op == 3'd2 || op == 3'd3) m_flg <= rel; else m_cc <= rel;
        if (op == 3'd1 || op == 3'd3) m_inv <= un && (sn || ca == 0 || cb == 0);
        else m_inv <= un;
      end else if (op == 3'd5) begin
        m_cc <= a_empty ? 3'd5 : 3'(ref_class(opa));
        m_c1 <= opa[79];
      end
    end else begin
      m_done <= 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      total++;
      if ({done, cc, c1, flg, invalid} !== {m_done, m_cc, m_c1, m_flg, m_inv}) begin
        bad++;
        $display("FAIL %s: got done=%b cc=%b c1=%b flg=%b inv=%b exp done=%b cc=%b c1=%b flg=%b inv=%b",
                 m_tag, done, cc, c1, flg, invalid, m_done, m_cc, m_c1, m_flg, m_inv);
      end
    end
  end

  task automatic apply(input logic [2:0] o, input logic [79:0] a, input logic [79:0] b,
                       input logic e, input string tag);
    @(negedge clk);
    in_valid = 1; op = o; opa = a; opb = b; a_empty = e; cur_tag = tag;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [79:0] pick(int k);
    case (k)
      0: return P_ZERO;  1: return N_ZERO;  2: return P_ONE;  3: return N_ONE;
      4: return P_TWO;   5: return N_TWO;   6: return P_1P5;  7: return P_INF;
      8: return N_INF;   9: return QNAN;    10: return SNAN;  11: return DENORM;
      12: return UNNORM; 13: return PSINF;
      default: return {$urandom, $urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({done, cc, c1, flg, invalid} !== 9'd0) begin
      bad++;
      $display("FAIL R12: got %b expected 000000000", {done, cc, c1, flg, invalid});
    end
    rst_n = 1;
    // R1 basic relations
    apply(3'd0, P_TWO, P_ONE, 0, "R1");
    apply(3'd0, P_ONE, P_TWO, 0, "R1");
    apply(3'd0, P_ONE, P_ONE, 0, "R1");
    // R7 ordering corners
    apply(3'd0, P_ZERO, N_ZERO, 0, "R7");
    apply(3'd0, N_ONE, N_TWO, 0, "R7");
    apply(3'd0, N_INF, DENORM, 0, "R7");
    apply(3'd0, P_1P5, P_ONE, 0, "R7");
    // R2 flag group
    apply(3'd2, P_ONE, P_TWO, 0, "R2");
    apply(3'd3, QNAN, P_ONE, 0, "R2");
    // R3 unsupported encodings
    apply(3'd0, UNNORM, P_ONE, 0, "R3");
    apply(3'd1, P_ONE, PSINF, 0, "R3");
    // R4 signalling mode with quiet NaN
    apply(3'd0, QNAN, P_ONE, 0, "R4");
    apply(3'd2, P_ONE, QNAN, 0, "R4");
    // R5 quiet mode
    apply(3'd1, QNAN, P_ONE, 0, "R5");
    apply(3'd1, SNAN, P_ONE, 0, "R5");
    apply(3'd3, P_ONE, SNAN, 0, "R5");
    // R6 test against zero, opb ignored
    apply(3'd4, N_ONE, QNAN, 0, "R6");
    apply(3'd4, N_ZERO, P_TWO, 0, "R6");
    apply(3'd4, QNAN, P_ZERO, 0, "R6");
    // R8 classify and empty tag
    for (int k = 0; k < 14; k++) apply(3'd5, pick(k), P_ONE, 0, "R8");
    apply(3'd5, P_ONE, P_ONE, 1, "R8");
    // R9 sign on C1
    apply(3'd5, N_INF, P_ZERO, 0, "R9");
    // R11 reserved opcodes
    apply(3'd6, P_ONE, P_TWO, 0, "R11");
    apply(3'd7, QNAN, SNAN, 0, "R11");
    // R10 random strobes, back to back and idle gaps
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_valid = $urandom_range(0, 1);
      op       = 3'($urandom_range(0, 7));
      opa      = pick($urandom_range(0, 15));
      opb      = pick($urandom_range(0, 15));
      a_empty  = ($urandom_range(0, 7) == 0);
      cur_tag  = "R10";
    end
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!fin) begin
      fin = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule